// File: doc/BRIEF.md
# DMA Channel Interrupt Flag Bank

This block gathers the event pulses of up to seven DMA channels into one read-only status word and drives one interrupt line per channel. Each channel signals three kinds of event: transfer complete, half transfer reached, and transfer error. Each event sets a sticky flag. A fourth flag per channel, the summary flag, reads as set while any of the other three is set.

Software reads the status word to find why a channel interrupted. It acknowledges flags by writing ones to a write-only clear word, which has the same layout as the status word. A channel's interrupt line is the OR of its three event flags, each masked by the channel's matching enable input.

A parameter sets how many channels are populated. A reduced instance, for example one with five channels, keeps the flags and interrupt lines of the missing channels at zero.

Top module: `dma_irq_flags`

## Requirements
- R1: After reset, the status word and all interrupt lines are zero.
- R2: Channel n (1..7) owns status bits 4(n-1)+3 down to 4(n-1). Within the group, bit 0 is the summary flag, bit 1 is complete, bit 2 is half transfer and bit 3 is error. An event pulse sampled at a clock edge sets its flag, and the flag is visible after that edge.
- R3: A flag, once set, stays set until it is cleared. Idle cycles do not change it.
- R4: The summary bit of a group reads 1 exactly when at least one of bits 1..3 of that group is 1.
- R5: A clear write (write strobe high) with a 1 in bit 1, 2 or 3 of a group clears only that flag. Bits written as 0 leave their flags unchanged.
- R6: A clear write with a 1 in the summary bit of a group clears all flags of that channel.
- R7: With the write strobe low, the clear data has no effect.
- R8: If an event and a clear of the same flag arrive in the same cycle, the flag is set after the edge.
- R9: A channel's interrupt line is high when (complete AND complete-enable) OR (half AND half-enable) OR (error AND error-enable). The enables do not alter the flags.
- R10: Status bits 31..28 always read 0.
- R11: For channels at or above USED_CH, the status group reads 0 and the interrupt line stays low, whatever their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ev_done_i | input | NUM_CH | Per-channel transfer-complete pulse |
| ev_half_i | input | NUM_CH | Per-channel half-transfer pulse |
| ev_err_i | input | NUM_CH | Per-channel transfer-error pulse |
| ie_done_i | input | NUM_CH | Per-channel complete interrupt enable |
| ie_half_i | input | NUM_CH | Per-channel half-transfer interrupt enable |
| ie_err_i | input | NUM_CH | Per-channel error interrupt enable |
| clr_we_i | input | 1 | Clear-word write strobe |
| clr_data_i | input | STAT_W | Clear word, write one to clear |
| status_o | output | STAT_W | Status word |
| irq_o | output | NUM_CH | Per-channel interrupt lines |

## Verification
The bench aims at the cases where a clear and an event meet in the same cycle. A design that gives the clear priority would lose an event. It also covers individual clears next to global clears: a design that decodes the summary clear bit wrongly would leave flags set, or would wipe flags that were not selected. Clear data written with the strobe low must leave every flag unchanged, which catches a decoder that ignores the strobe. A second instance with five channels, with every input driven, shows that the unused groups and the top nibble stay zero, and that the enables gate only the interrupt lines, never the flags.

// File: rtl/dma_flag_pkg.sv
package dma_flag_pkg;
  localparam int GRP_W  = 4;  // flags per channel group
  localparam int EV_W   = 3;  // event flags: {err, half, done}
  localparam int F_GLB  = 0;
  localparam int F_DONE = 1;
  localparam int F_HALF = 2;
  localparam int F_ERR  = 3;
endpackage

// File: rtl/dma_chan_flags.sv
module dma_chan_flags
  import dma_flag_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EV_W-1:0]  ev_i,       // {err, half, done}
  input  logic             clr_we_i,
  input  logic [GRP_W-1:0] clr_grp_i,  // {err, half, done, glb}
  output logic [GRP_W-1:0] grp_o,
  output logic [EV_W-1:0]  flag_o
);
  logic [EV_W-1:0] flag_q;
  logic [EV_W-1:0] clr_mask;

  // summary clear bit widens to the whole group
  assign clr_mask = clr_we_i ? (clr_grp_i[GRP_W-1:1] | {EV_W{clr_grp_i[F_GLB]}})
                             : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_mask) | ev_i;  // event wins
  end

  assign flag_o = flag_q;
  assign grp_o  = {flag_q, |flag_q};

  // R8
  evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i != '0) |=> ((flag_q & $past(ev_i)) == $past(ev_i)));

  // R3
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R6
  glb_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && clr_grp_i[F_GLB] && ev_i == '0) |=> (grp_o == '0));

  // R5
  fell_needs_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(grp_o[F_GLB]) |-> $past(clr_we_i));
endmodule

// File: rtl/dma_irq_gate.sv
module dma_irq_gate
  import dma_flag_pkg::*;
(
  input  logic [EV_W-1:0] flag_i,
  input  logic [EV_W-1:0] ie_i,
  output logic            irq_o
);
  assign irq_o = |(flag_i & ie_i);
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
  import dma_flag_pkg::*;
#(
  parameter int NUM_CH  = 7,
  parameter int USED_CH = 7,
  parameter int STAT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] ev_done_i,
  input  logic [NUM_CH-1:0] ev_half_i,
  input  logic [NUM_CH-1:0] ev_err_i,
  input  logic [NUM_CH-1:0] ie_done_i,
  input  logic [NUM_CH-1:0] ie_half_i,
  input  logic [NUM_CH-1:0] ie_err_i,
  input  logic              clr_we_i,
  input  logic [STAT_W-1:0] clr_data_i,
  output logic [STAT_W-1:0] status_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int GRPS_W = NUM_CH * GRP_W;
  localparam int PAD_W  = STAT_W - GRPS_W;

  logic [GRPS_W-1:0] grp_all;
  logic              unused_pad;

  assign unused_pad = ^clr_data_i[STAT_W-1:GRPS_W];
  assign status_o   = {{PAD_W{1'b0}}, grp_all};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    if (c < USED_CH) begin : g_used
      logic [EV_W-1:0] flag;
      dma_chan_flags u_flags (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ev_i      ({ev_err_i[c], ev_half_i[c], ev_done_i[c]}),
        .clr_we_i  (clr_we_i),
        .clr_grp_i (clr_data_i[c*GRP_W +: GRP_W]),
        .grp_o     (grp_all[c*GRP_W +: GRP_W]),
        .flag_o    (flag)
      );
      dma_irq_gate u_gate (
        .flag_i (flag),
        .ie_i   ({ie_err_i[c], ie_half_i[c], ie_done_i[c]}),
        .irq_o  (irq_o[c])
      );
    end else begin : g_unused
      logic unused_in;
      assign unused_in = ^{ev_done_i[c], ev_half_i[c], ev_err_i[c],
                           ie_done_i[c], ie_half_i[c], ie_err_i[c],
                           clr_data_i[c*GRP_W +: GRP_W]};
      assign grp_all[c*GRP_W +: GRP_W] = '0;
      assign irq_o[c] = 1'b0;
    end
  end
endmodule

// File: tb/dma_irq_flags_tb.sv
module dma_irq_flags_tb;
  localparam int N = 7;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [N-1:0] ev_done = '0, ev_half = '0, ev_err = '0;
  logic [N-1:0] ie_done = '0, ie_half = '0, ie_err = '0;
  logic        clr_we = 1'b0;
  logic [31:0] clr_data = '0;
  logic [31:0] status, status5;
  logic [N-1:0] irq, irq5;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  dma_irq_flags u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ev_done_i(ev_done), .ev_half_i(ev_half), .ev_err_i(ev_err),
    .ie_done_i(ie_done), .ie_half_i(ie_half), .ie_err_i(ie_err),
    .clr_we_i(clr_we), .clr_data_i(clr_data),
    .status_o(status), .irq_o(irq)
  );

  dma_irq_flags #(.USED_CH(5)) u_dut5 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ev_done_i(ev_done), .ev_half_i(ev_half), .ev_err_i(ev_err),
    .ie_done_i(ie_done), .ie_half_i(ie_half), .ie_err_i(ie_err),
    .clr_we_i(clr_we), .clr_data_i(clr_data),
    .status_o(status5), .irq_o(irq5)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic fire(input logic [N-1:0] d, input logic [N-1:0] h, input logic [N-1:0] e);
    ev_done = d; ev_half = h; ev_err = e;
    tick();
    ev_done = '0; ev_half = '0; ev_err = '0;
  endtask

  task automatic clear(input logic [31:0] data);
    clr_we = 1'b1; clr_data = data;
    tick();
    clr_we = 1'b0; clr_data = '0;
  endtask

  task automatic t_reset();
    chk("R1 status", status, 32'h0);
    chk("R1 irq", {25'h0, irq}, 32'h0);
  endtask

  task automatic t_each_done();
    for (int ch = 0; ch < N; ch++) begin
      fire(7'(1 << ch), '0, '0);
      // R2 R4: complete bit 1 plus summary bit 0 of group ch
      chk("R2 done layout", status, 32'h3 << (4 * ch));
      clear(32'h1 << (4 * ch));  // R6 summary clear
      chk("R6 summary clear", status, 32'h0);
    end
  endtask

  task automatic t_half_err();
    fire('0, 7'b0000100, 7'b0010000);
    chk("R2 half/err layout", status, 32'h0009_0500);
    repeat (5) tick();
    chk("R3 sticky", status, 32'h0009_0500);
    clear(32'h0FFF_FFFF);
    chk("R6 clear all", status, 32'h0);
  endtask

  task automatic t_indiv_clear();
    fire(7'b0000010, 7'b0000010, '0);
    chk("R4 summary set", status, 32'h70);
    clear(32'h20);
    chk("R5 clear done only", status, 32'h50);
    clear(32'h0);
    chk("R5 zero write", status, 32'h50);
    clear(32'h40);
    chk("R5 clear half, R4 summary drops", status, 32'h0);
  endtask

  task automatic t_no_strobe();
    fire('1, '0, '0);
    clr_we = 1'b0; clr_data = 32'hFFFF_FFFF;
    tick();
    clr_data = '0;
    chk("R7 no strobe", status, 32'h0333_3333);
    clear(32'h0111_1111);
    chk("R7 cleanup", status, 32'h0);
  endtask

  task automatic t_evt_wins();
    ev_err = 7'b0000001; clr_we = 1'b1; clr_data = 32'h9;
    tick();
    ev_err = '0; clr_we = 1'b0; clr_data = '0;
    chk("R8 event wins", status, 32'h9);
    clear(32'h1);
    chk("R8 cleanup", status, 32'h0);
  endtask

  task automatic t_irq();
    fire(7'b0001000, '0, '0);
    chk("R9 no enable", {25'h0, irq}, 32'h0);
    ie_half = '1; ie_err = '1;
    #1 chk("R9 other enables", {25'h0, irq}, 32'h0);
    ie_done = 7'b0001000; ie_half = '0; ie_err = '0;
    #1 chk("R9 done enabled", {25'h0, irq}, 32'h08);
    chk("R9 flags untouched", status, 32'h3000);
    clear(32'h2000);
    chk("R9 irq drops", {25'h0, irq}, 32'h0);
    ie_done = '0;
  endtask

  task automatic t_all_and_unused();
    ie_done = '1; ie_half = '1; ie_err = '1;
    fire('1, '1, '1);
    chk("R10 top nibble", status, 32'h0FFF_FFFF);
    chk("R9 all irq", {25'h0, irq}, 32'h7F);
    chk("R11 unused status", status5, 32'h000F_FFFF);
    chk("R11 unused irq", {25'h0, irq5}, 32'h1F);
    clear(32'hFFFF_FFFF);
    chk("R6 clear all", status, 32'h0);
    ie_done = '0; ie_half = '0; ie_err = '0;
  endtask

  initial begin
    #(10 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #23;
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_each_done();
    t_half_err();
    t_indiv_clear();
    t_no_strobe();
    t_evt_wins();
    t_irq();
    t_all_and_unused();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule